// File: doc/BRIEF.md
# Multi-Mode Pixel Counter with Serial Shift Readout

This block is the digital back end of a single pixel in a photon-counting imaging matrix. A discriminator input signals that the pixel charge is above its threshold. While the shutter is open, one 14-bit register does one of three jobs. It can count hits. It can add up the clock cycles that the discriminator spends high. Or it can time how long ago the first hit arrived. The count stops at 11810 and stays there.

When readout is requested, acquisition stops and the same register becomes one stage of a serial chain. It passes bits MSB first from a serial input to a serial output, one bit per clock. Pixels are chained by connecting each serial output to the neighbour's serial input.

A three-state controller sets the phase of the pixel. The states are `ST_IDLE` (shutter closed), `ST_ACQ` (shutter open) and `ST_SHIFT` (readout). The transitions are:
- reset to `ST_IDLE`;
- `ST_IDLE` to `ST_ACQ` when the shutter opens without readout;
- `ST_ACQ` to `ST_IDLE` when the shutter closes;
- any state to `ST_SHIFT` when readout is requested;
- `ST_SHIFT` to `ST_IDLE` when the request drops.

Top module: `hitpix_cell`

## Requirements
- R1: After reset the register holds zero, `sdo` is 0 and the mode is event counting (code 00).
- R2: Mode code 00 (event counting) adds one for each rising edge of the synchronized discriminator seen while the shutter is open. Pulses while the shutter is closed add nothing.
- R3: Mode code 01 (time over threshold) adds one for every clock in which the synchronized discriminator is high and the shutter is open. A pulse held for N clocks inside the window adds N.
- R4: Mode code 10 (time of arrival) starts on the first synchronized rising edge and adds one per clock until the shutter closes. The count includes the edge clock and the clock in which the closed shutter is sampled. If the discriminator is driven high K clocks before the shutter is dropped, the result is K-1. Later hits change nothing, and a window with no hit reads 0.
- R5: The register never advances past 11810. Once there, it holds that value until it is cleared or shifted.
- R6: While `ro_en` is high, from the second clock edge onward, each clock shifts the register left by one. `sdi` enters bit 0 and `sdo` always shows bit 13. Fourteen shifts move a full word MSB first, and counting is frozen throughout.
- R7: `clr` zeroes the register and re-arms the first-hit latch of mode 10, with priority over counting and shifting.
- R8: `mode` is sampled only while the controller is in `ST_IDLE`. A change made while the shutter is open has no effect on that window.
- R9: Mode code 11 (hold) leaves the register unchanged whatever the discriminator does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of register and first-hit latch |
| shutter | input | 1 | Acquisition window, high = open |
| disc | input | 1 | Asynchronous discriminator output |
| mode | input | 2 | Acquisition mode code |
| ro_en | input | 1 | Readout request |
| sdi | input | 1 | Serial input from the previous pixel |
| sdo | output | 1 | Serial output, register MSB |

## Verification
The discriminator reaches the datapath through two synchronizer flops. A level or edge driven before clock edge 1 therefore first changes the register at edge 3, and the expected values for time over threshold and time of arrival are N and K-1 because of that offset. The controller state is also registered. Counting starts on the second edge after the shutter opens and continues through the edge that samples it closed. The first shift happens on the second edge after `ro_en` rises. The bench drives inputs on falling edges and waits several idle cycles around every shutter and readout transition. It samples `sdo` on the falling edge before each shift edge. Sweeps over pulse counts, widths and arrival offsets are compared against these arithmetic formulas.

// File: rtl/hitpix_pkg.sv
package hitpix_pkg;

    typedef enum logic [1:0] {
        MODE_EVENT = 2'b00,
        MODE_TOT   = 2'b01,
        MODE_TOA   = 2'b10,
        MODE_HOLD  = 2'b11
    } pix_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ACQ   = 2'b01,
        ST_SHIFT = 2'b10
    } pix_state_e;

endpackage

// File: rtl/hitpix_sync.sv
module hitpix_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign lvl  = chain_q[STAGES-1];
    assign rise = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/hitpix_ctrl.sv
module hitpix_ctrl
    import hitpix_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shutter,
    input  logic       ro_en,
    input  logic [1:0] mode,
    output logic       acq_en,
    output logic       shift_en,
    output pix_mode_e  mode_q
);
    pix_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ro_en) state_d = ST_SHIFT;
                      else if (shutter) state_d = ST_ACQ;
            ST_ACQ:   if (ro_en) state_d = ST_SHIFT;
                      else if (!shutter) state_d = ST_IDLE;
            ST_SHIFT: if (!ro_en) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_EVENT;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)
                mode_q <= pix_mode_e'(mode);
        end
    end

    always_comb begin
        acq_en   = 1'b0;
        shift_en = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ACQ:   acq_en   = ~ro_en;
            ST_SHIFT: shift_en = ro_en;
            default:  ;
        endcase
    end

    // R8: mode is frozen outside the idle state
    a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(mode_q));

    // R6: a shift phase is only entered on a readout request
    a_r6_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SHIFT && !ro_en) |=> (state_q != ST_SHIFT));

endmodule

// File: rtl/hitpix_reg.sv
module hitpix_reg
    import hitpix_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int SAT_LIMIT = 11810
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             acq_en,
    input  logic             shift_en,
    input  pix_mode_e        mode_q,
    input  logic             hit_lvl,
    input  logic             hit_rise,
    input  logic             sdi,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] SAT_Q = CNT_W'(SAT_LIMIT);

    logic armed_hit_q;
    logic inc;

    always_comb begin
        inc = 1'b0;
        unique case (mode_q)
            MODE_EVENT: inc = hit_rise;
            MODE_TOT:   inc = hit_lvl;
            MODE_TOA:   inc = armed_hit_q | hit_rise;
            MODE_HOLD:  inc = 1'b0;
            default:    inc = 1'b0;
        endcase
        inc = inc & acq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            armed_hit_q <= 1'b0;
        end else if (clr) begin
            cnt_q       <= '0;
            armed_hit_q <= 1'b0;
        end else if (shift_en) begin
            cnt_q <= {cnt_q[CNT_W-2:0], sdi};
        end else begin
            if (acq_en && mode_q == MODE_TOA && hit_rise)
                armed_hit_q <= 1'b1;
            if (inc && cnt_q != SAT_Q)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: a saturated register stays put unless cleared or shifted
    a_r5_hold_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == SAT_Q && !clr && !shift_en) |=> (cnt_q == SAT_Q));

    // R4: the first-hit latch only drops through clear
    a_r4_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_hit_q && !clr) |=> armed_hit_q);

    // R6: a shift loads the serial input into bit 0
    a_r6_serial_in: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr) |=> (cnt_q[0] == $past(sdi)));

    // R7: clear leaves the register at zero
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R6: no change without acquisition, shift or clear
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_en && !shift_en && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/hitpix_cell.sv
module hitpix_cell
    import hitpix_pkg::*;
#(
    parameter int CNT_W       = 14,
    parameter int SAT_LIMIT   = 11810,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       shutter,
    input  logic       disc,
    input  logic [1:0] mode,
    input  logic       ro_en,
    input  logic       sdi,
    output logic       sdo
);
    logic             hit_lvl;
    logic             hit_rise;
    logic             acq_en;
    logic             shift_en;
    pix_mode_e        mode_q;
    logic [CNT_W-1:0] cnt_q;

    hitpix_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (disc),
        .lvl  (hit_lvl),
        .rise (hit_rise)
    );

    hitpix_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .shutter (shutter),
        .ro_en   (ro_en),
        .mode    (mode),
        .acq_en  (acq_en),
        .shift_en(shift_en),
        .mode_q  (mode_q)
    );

    hitpix_reg #(.CNT_W(CNT_W), .SAT_LIMIT(SAT_LIMIT)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .acq_en  (acq_en),
        .shift_en(shift_en),
        .mode_q  (mode_q),
        .hit_lvl (hit_lvl),
        .hit_rise(hit_rise),
        .sdi     (sdi),
        .cnt_q   (cnt_q)
    );

    assign sdo = cnt_q[CNT_W-1];

    // R1, R6: the serial output tracks the top register bit
    a_r1_sdo_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr) |=> (sdo == $past(cnt_q[CNT_W-2])));

endmodule

// File: tb/hitpix_cell_tb.sv
module hitpix_cell_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 14;
    localparam int SAT = 11810;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, shutter = 1'b0, disc = 1'b0, ro_en = 1'b0, sdi = 1'b0;
    logic [1:0] mode = 2'b00;
    logic sdo;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hitpix_cell u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .shutter(shutter), .disc(disc),
        .mode(mode), .ro_en(ro_en), .sdi(sdi), .sdo(sdo)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic read_word(input logic [W-1:0] load, output logic [W-1:0] got);
        ro_en = 1'b1;
        cyc(1);
        for (int i = W-1; i >= 0; i--) begin
            got[i] = sdo;
            sdi = load[i];
            cyc(1);
        end
        ro_en = 1'b0;
        sdi = 1'b0;
        cyc(2);
    endtask

    task automatic check_value(input string req, input int exp);
        logic [W-1:0] got;
        read_word('0, got);
        chk(req, int'(got), exp);
    endtask

    task automatic do_clear();
        clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode = m; cyc(2);
    endtask

    task automatic open_win();
        shutter = 1'b1; cyc(3);
    endtask

    task automatic close_win();
        shutter = 1'b0; cyc(3);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            disc = 1'b1; cyc(2); disc = 1'b0; cyc(2);
        end
        cyc(3);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] got;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1: reset state
        chk("R1 sdo", int'(sdo), 0);
        check_value("R1 reset value", 0);
        // R1: default mode counts events
        open_win(); pulses(3); close_win();
        check_value("R1 default mode", 3);

        // R2: event count sweep, hits while closed ignored
        for (int n = 0; n <= 12; n++) begin
            do_clear(); set_mode(2'b00);
            pulses(2);
            open_win(); pulses(n); close_win();
            pulses(2);
            check_value("R2 event count", n);
        end

        // R3: time over threshold sweep, single and split pulses
        for (int n = 1; n <= 20; n++) begin
            do_clear(); set_mode(2'b01);
            open_win();
            disc = 1'b1; cyc(n); disc = 1'b0; cyc(3);
            disc = 1'b1; cyc(n + 1); disc = 1'b0; cyc(4);
            close_win();
            check_value("R3 tot sum", 2 * n + 1);
        end

        // R4: arrival time sweep
        for (int k = 3; k <= 25; k++) begin
            do_clear(); set_mode(2'b10);
            open_win(); cyc(k);
            disc = 1'b1; cyc(k); shutter = 1'b0; disc = 1'b0; cyc(3);
            check_value("R4 toa single", k - 1);
        end
        // R4: later hit ignored
        for (int k = 8; k <= 16; k += 4) begin
            do_clear(); set_mode(2'b10);
            open_win();
            disc = 1'b1; cyc(2); disc = 1'b0; cyc(3);
            disc = 1'b1; cyc(k - 5); shutter = 1'b0; disc = 1'b0; cyc(3);
            check_value("R4 toa second hit", k - 1);
        end
        // R4: no hit reads zero
        do_clear(); set_mode(2'b10);
        open_win(); cyc(20); close_win();
        check_value("R4 toa no hit", 0);

        // R5: saturation in tot mode
        do_clear(); set_mode(2'b01);
        open_win();
        disc = 1'b1; cyc(SAT + 100); disc = 1'b0; cyc(4);
        close_win();
        check_value("R5 saturate", SAT);

        // R6: shift chain carries an arbitrary word MSB first
        do_clear();
        read_word(14'h2A5C, got);
        chk("R6 first out", int'(got), 0);
        read_word(14'h13F1, got);
        chk("R6 chained word", int'(got), 14'h2A5C);
        read_word(14'h0000, got);
        chk("R6 chained word 2", int'(got), 14'h13F1);
        // R6: counting frozen during readout
        do_clear(); set_mode(2'b01);
        open_win();
        disc = 1'b1; cyc(5);
        read_word('0, got);
        chk("R6 frozen read", int'(got), 3);
        disc = 1'b0; cyc(4);
        close_win();

        // R7: clear zeroes and re-arms first hit
        do_clear(); set_mode(2'b10);
        open_win(); disc = 1'b1; cyc(6); disc = 1'b0; cyc(2); close_win();
        do_clear();
        open_win(); cyc(10); close_win();
        check_value("R7 rearm", 0);
        do_clear(); set_mode(2'b00);
        open_win(); pulses(4); close_win();
        do_clear();
        check_value("R7 clear", 0);

        // R8: mode change while open ignored
        do_clear(); set_mode(2'b01);
        open_win(); mode = 2'b00; cyc(2);
        disc = 1'b1; cyc(9); disc = 1'b0; cyc(4);
        close_win();
        check_value("R8 mode held", 9);

        // R9: hold mode
        do_clear(); set_mode(2'b11);
        open_win(); pulses(5); disc = 1'b1; cyc(7); disc = 1'b0; cyc(3); close_win();
        check_value("R9 hold", 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule